// File: doc/BRIEF.md
# Bus-Stall Scheduler for Audio Sample and Sprite Copy DMA

This block decides, cycle by cycle, when a 6502-style CPU must give up the bus. Two engines compete for it. The sample engine fetches one byte for an audio channel. The sprite engine copies a 256-byte table as alternating reads and writes. The block keeps a get/put parity flag that flips every CPU cycle. It watches the CPU write strobe and address, and a sample request line. It drives a ready line (low means stall), a bus-ownership flag, and one marker pulse for each DMA access.

A sample fetch can be launched by a write to the channel enable register. That kind of fetch is followed by two side effects. The first is a spurious four-cycle reload stall. The second is a single-cycle ready drop two cycles after that stall ends. The scheduler reproduces both, including the cases where the CPU is writing or the sprite engine is running.

The CPU can only be halted on a read. A write that is in progress carries on, and the stall starts on the next read. Timing is stated in cycles counted from the halt cycle. The first cycle after reset is a get cycle.

Top module: `dma_cycle_sched`

## Requirements
- R1: The parity output `putCycle` is 0 in the first cycle after reset and then inverts on every clock.
- R2: Once a DMA is pending, `cpuRdy` is low. The bus is taken (`dmaOwn` high) only in a cycle where `cpuWrite` is 0, so pending DMA waits out any write cycles.
- R3: A fetch requested with `sampleReq` in cycle q becomes pending in cycle q+1. Its byte is read (`sampleSlot`) on the first get cycle at least two cycles after the halt cycle h. The stall is therefore 3 cycles when h is a get cycle and 4 cycles when h is a put cycle.
- R4: A write to `SPRITE_ADDR` starts 256 read/write pairs. Reads fall on get cycles (`spriteRdSlot`) and writes on put cycles (`spriteWrSlot`). Reads begin on the first get cycle after the halt cycle. The stall is 514 cycles when the halt falls on a get cycle (launch write on a put cycle) and 513 cycles when it falls on a put cycle.
- R5: If a sample fetch and a sprite copy halt in the same cycle (request raised in the launch-write cycle), the combined stall is exactly the sprite stall plus 2 cycles, for either parity.
- R6: A sample fetch that arrives while the sprite copy runs takes the next get slot, then leaves one idle put cycle. This lengthens the copy by exactly 2 cycles.
- R7: A fetch started by a write to `ENABLE_ADDR` is followed directly by a 4-cycle reload stall. The reload starts on the put cycle after the fetch and ends with `reloadSlot` on its fourth cycle, which is a get cycle.
- R8: When that fetch and its reload fall inside a sprite copy, each costs 2 cycles. An enable write followed at once by a sprite launch write therefore stalls the sprite length plus 4.
- R9: Two cycles after the reload's last cycle, `cpuRdy` drops for exactly one cycle if the CPU is reading then. This adds one stall cycle.
- R10: The single-cycle drop is skipped entirely when the CPU cycle at that slot is a write.
- R11: A single-cycle drop that falls while the sprite engine is busy adds no cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | ADDR_W | Address of the current CPU cycle |
| cpuWrite | input | 1 | 1 when the current CPU cycle is a write |
| sampleReq | input | 1 | Plain sample fetch request (one-cycle pulse) |
| cpuRdy | output | 1 | 0 stalls the CPU on a read cycle |
| dmaOwn | output | 1 | A DMA engine owns the bus this cycle |
| putCycle | output | 1 | 1 on put cycles, 0 on get cycles |
| sampleSlot | output | 1 | Sample byte is read this cycle |
| reloadSlot | output | 1 | Spurious reload read this cycle |
| spriteRdSlot | output | 1 | Sprite copy source read this cycle |
| spriteWrSlot | output | 1 | Sprite copy destination write this cycle |

## Verification
The sample engine and the sprite engine can both want the halt cycle, or the same get slot, in one cycle. The bench provokes this in three ways. It raises the sample request in the same cycle as the sprite launch write. It writes the enable register directly before the launch write. It injects a request partway through the copy. Start parity and the number of intervening writes are varied at random. Each case is judged by the exact number of cycles the CPU is held against a closed-form expectation: plus 2 for one shared slot, plus 4 with the reload, and no extra cycle from the ready drop. The bench also counts every access marker and checks that it falls on the correct parity.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

  typedef enum logic [2:0] {
    SM_IDLE,
    SM_WAIT,
    SM_RUN,
    SM_RELOAD,
    SM_RLDWAIT
  } smpState_t;

  typedef enum logic [1:0] {
    SP_IDLE,
    SP_WAIT,
    SP_RUN
  } sprState_t;

  // strobes from control to datapath counters
  typedef struct packed {
    logic smpStart;
    logic smpInc;
    logic rldClr;
    logic rldInc;
    logic sprClr;
    logic sprInc;
    logic dropArm;
  } ctlStrobe_t;

endpackage

// File: rtl/dma_sched_datapath.sv
module dma_sched_datapath
  import dma_sched_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SPRITE_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'h4015,
  parameter int BYTES       = 256,
  parameter int RELOAD_LEN  = 4,
  parameter int DROP_GAP    = 2,
  parameter int SMP_GAP     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              put,
  output logic              sprHit,
  output logic              enHit,
  output logic              smpReady,
  output logic              rldLast,
  output logic              sprLast,
  output logic              dropNow
);

  localparam int SPR_CW  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int RLD_CW  = (RELOAD_LEN > 1) ? $clog2(RELOAD_LEN) : 1;
  localparam int DROP_CW = $clog2(DROP_GAP + 1);
  localparam int SMP_CW  = $clog2(SMP_GAP + 1);

  logic               putQ;
  logic [SMP_CW-1:0]  smpCnt;
  logic [RLD_CW-1:0]  rldCnt;
  logic [SPR_CW-1:0]  sprCnt;
  logic [DROP_CW-1:0] dropTmr;

  // get/put parity: first cycle out of reset is a get
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) putQ <= 1'b0;
    else       putQ <= ~putQ;
  end
  assign put = putQ;

  assign sprHit = (cpuAddr == SPRITE_ADDR);
  assign enHit  = (cpuAddr == ENABLE_ADDR);

  // cycles elapsed since the sample halt, saturating at the gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             smpCnt <= '0;
    else if (stb.smpStart)                 smpCnt <= SMP_CW'(1);
    else if (stb.smpInc && !smpReady)      smpCnt <= smpCnt + SMP_CW'(1);
  end
  assign smpReady = (smpCnt >= SMP_CW'(SMP_GAP));

  // position inside the spurious reload stall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rldCnt <= '0;
    else if (stb.rldClr) rldCnt <= '0;
    else if (stb.rldInc) rldCnt <= rldCnt + RLD_CW'(1);
  end
  assign rldLast = (rldCnt == RLD_CW'(RELOAD_LEN - 1));

  // bytes written by the sprite copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sprCnt <= '0;
    else if (stb.sprClr) sprCnt <= '0;
    else if (stb.sprInc) sprCnt <= sprCnt + SPR_CW'(1);
  end
  assign sprLast = (sprCnt == SPR_CW'(BYTES - 1));

  // countdown to the single-cycle ready drop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dropTmr <= '0;
    else if (stb.dropArm)      dropTmr <= DROP_CW'(DROP_GAP);
    else if (dropTmr != '0)    dropTmr <= dropTmr - DROP_CW'(1);
  end
  assign dropNow = (dropTmr == DROP_CW'(1));

endmodule

// File: rtl/dma_sched_ctrl.sv
module dma_sched_ctrl
  import dma_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrite,
  input  logic       sampleReq,
  input  logic       put,
  input  logic       sprHit,
  input  logic       enHit,
  input  logic       smpReady,
  input  logic       rldLast,
  input  logic       sprLast,
  input  logic       dropNow,
  output ctlStrobe_t stb,
  output logic       cpuRdy,
  output logic       dmaOwn,
  output logic       sampleSlot,
  output logic       reloadSlot,
  output logic       spriteRdSlot,
  output logic       spriteWrSlot
);

  smpState_t smpQ, smpD;
  sprState_t sprQ, sprD;
  logic      isLoadQ, isLoadD;
  logic      haveQ, haveD;
  logic      sprBusy, stealSlot, smpPend, smpOwn, sprOwn, dropStall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpQ    <= SM_IDLE;
      sprQ    <= SP_IDLE;
      isLoadQ <= 1'b0;
      haveQ   <= 1'b0;
    end else begin
      smpQ    <= smpD;
      sprQ    <= sprD;
      isLoadQ <= isLoadD;
      haveQ   <= haveD;
    end
  end

  assign sprBusy = (sprQ != SP_IDLE);
  assign smpPend = (smpQ == SM_WAIT) || (smpQ == SM_RLDWAIT);
  // a pending sample access replaces a sprite read on a get slot
  assign stealSlot = (sprQ == SP_RUN) && !put && smpPend;

  // sprite copy engine
  always_comb begin
    sprD         = sprQ;
    haveD        = haveQ;
    sprOwn       = 1'b0;
    spriteRdSlot = 1'b0;
    spriteWrSlot = 1'b0;
    stb.sprClr   = 1'b0;
    stb.sprInc   = 1'b0;
    unique case (sprQ)
      SP_IDLE: begin
        if (cpuWrite && sprHit) begin
          sprD       = SP_WAIT;
          stb.sprClr = 1'b1;
          haveD      = 1'b0;
        end
      end
      SP_WAIT: begin
        if (!cpuWrite) begin
          sprOwn = 1'b1;
          sprD   = SP_RUN;
        end
      end
      SP_RUN: begin
        sprOwn = 1'b1;
        if (!put) begin
          if (!stealSlot) begin
            spriteRdSlot = 1'b1;
            haveD        = 1'b1;
          end
        end else if (haveQ) begin
          spriteWrSlot = 1'b1;
          haveD        = 1'b0;
          stb.sprInc   = 1'b1;
          if (sprLast) sprD = SP_IDLE;
        end
      end
      default: sprD = SP_IDLE;
    endcase
  end

  // sample fetch engine with reload and drop side effects
  always_comb begin
    smpD        = smpQ;
    isLoadD     = isLoadQ;
    smpOwn      = 1'b0;
    sampleSlot  = 1'b0;
    reloadSlot  = 1'b0;
    stb.smpStart = 1'b0;
    stb.smpInc  = 1'b0;
    stb.rldClr  = 1'b0;
    stb.rldInc  = 1'b0;
    stb.dropArm = 1'b0;
    unique case (smpQ)
      SM_IDLE: begin
        if (sampleReq || (cpuWrite && enHit)) begin
          smpD    = SM_WAIT;
          isLoadD = cpuWrite && enHit;
        end
      end
      SM_WAIT: begin
        if (stealSlot) begin
          sampleSlot = 1'b1;
          smpD       = isLoadQ ? SM_RLDWAIT : SM_IDLE;
        end else if (!sprBusy && !cpuWrite) begin
          smpOwn       = 1'b1;
          stb.smpStart = 1'b1;
          smpD         = SM_RUN;
        end
      end
      SM_RUN: begin
        smpOwn     = 1'b1;
        stb.smpInc = 1'b1;
        if (smpReady && !put) begin
          sampleSlot = 1'b1;
          if (isLoadQ) begin
            smpD       = SM_RELOAD;
            stb.rldClr = 1'b1;
          end else begin
            smpD = SM_IDLE;
          end
        end
      end
      SM_RELOAD: begin
        smpOwn     = 1'b1;
        stb.rldInc = 1'b1;
        if (rldLast) begin
          reloadSlot  = 1'b1;
          stb.dropArm = 1'b1;
          smpD        = SM_IDLE;
        end
      end
      SM_RLDWAIT: begin
        if (stealSlot) begin
          reloadSlot  = 1'b1;
          stb.dropArm = 1'b1;
          smpD        = SM_IDLE;
        end
      end
      default: smpD = SM_IDLE;
    endcase
  end

  assign dropStall = dropNow && !cpuWrite && !sprBusy;
  assign cpuRdy    = !(sprBusy || (smpQ != SM_IDLE) || dropStall);
  assign dmaOwn    = sprOwn || smpOwn;

endmodule

// File: rtl/dma_cycle_sched.sv
module dma_cycle_sched
  import dma_sched_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SPRITE_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 16'h4015,
  parameter int BYTES       = 256,
  parameter int RELOAD_LEN  = 4,
  parameter int DROP_GAP    = 2,
  parameter int SMP_GAP     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrite,
  input  logic              sampleReq,
  output logic              cpuRdy,
  output logic              dmaOwn,
  output logic              putCycle,
  output logic              sampleSlot,
  output logic              reloadSlot,
  output logic              spriteRdSlot,
  output logic              spriteWrSlot
);

  ctlStrobe_t stb;
  logic put, sprHit, enHit, smpReady, rldLast, sprLast, dropNow;

  dma_sched_datapath #(
    .ADDR_W(ADDR_W), .SPRITE_ADDR(SPRITE_ADDR), .ENABLE_ADDR(ENABLE_ADDR),
    .BYTES(BYTES), .RELOAD_LEN(RELOAD_LEN), .DROP_GAP(DROP_GAP), .SMP_GAP(SMP_GAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuAddr(cpuAddr),
    .put(put), .sprHit(sprHit), .enHit(enHit), .smpReady(smpReady),
    .rldLast(rldLast), .sprLast(sprLast), .dropNow(dropNow)
  );

  dma_sched_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .cpuWrite(cpuWrite), .sampleReq(sampleReq),
    .put(put), .sprHit(sprHit), .enHit(enHit), .smpReady(smpReady),
    .rldLast(rldLast), .sprLast(sprLast), .dropNow(dropNow), .stb(stb),
    .cpuRdy(cpuRdy), .dmaOwn(dmaOwn), .sampleSlot(sampleSlot),
    .reloadSlot(reloadSlot), .spriteRdSlot(spriteRdSlot),
    .spriteWrSlot(spriteWrSlot)
  );

  assign putCycle = put;

endmodule

// File: rtl/dma_cycle_sched_chk.sv
module dma_cycle_sched_chk (
  input logic clk,
  input logic rstN,
  input logic cpuWrite,
  input logic putCycle,
  input logic cpuRdy,
  input logic dmaOwn,
  input logic sampleSlot,
  input logic reloadSlot,
  input logic spriteRdSlot,
  input logic spriteWrSlot
);

  p_put_flips_r1: assert property (@(posedge clk) disable iff (!rstN)
    putCycle |=> !putCycle);
  p_get_flips_r1: assert property (@(posedge clk) disable iff (!rstN)
    !putCycle |=> putCycle);

  p_halt_on_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaOwn) |-> !cpuWrite);

  p_sample_on_get_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleSlot |-> !putCycle);

  p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    spriteRdSlot |=> spriteWrSlot);
  p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rstN)
    spriteWrSlot |-> $past(spriteRdSlot));

  p_reload_on_get_r7: assert property (@(posedge clk) disable iff (!rstN)
    reloadSlot |-> !putCycle);

  // R6: a slot serves one engine only
  p_one_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleSlot, reloadSlot, spriteRdSlot, spriteWrSlot}));

  // R2: any DMA access means the bus is held and the CPU stalled
  p_slot_owned_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleSlot || reloadSlot || spriteRdSlot || spriteWrSlot) |-> (dmaOwn && !cpuRdy));

endmodule

bind dma_cycle_sched dma_cycle_sched_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuWrite(cpuWrite), .putCycle(putCycle),
  .cpuRdy(cpuRdy), .dmaOwn(dmaOwn), .sampleSlot(sampleSlot),
  .reloadSlot(reloadSlot), .spriteRdSlot(spriteRdSlot), .spriteWrSlot(spriteWrSlot)
);

// File: tb/sim_dma_cycle_sched.sv
module sim_dma_cycle_sched;

  localparam logic [15:0] SPR_A = 16'h4014;
  localparam logic [15:0] EN_A  = 16'h4015;
  localparam logic [15:0] RD_A  = 16'h8000;
  localparam logic [15:0] WR_A  = 16'h0200;
  localparam int LIMIT = 190000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cpuWrite, sampleReq;
  logic [15:0] cpuAddr;
  logic cpuRdy, dmaOwn, putCycle, sampleSlot, reloadSlot, spriteRdSlot, spriteWrSlot;

  dma_cycle_sched u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .sampleReq(sampleReq), .cpuRdy(cpuRdy), .dmaOwn(dmaOwn), .putCycle(putCycle),
    .sampleSlot(sampleSlot), .reloadSlot(reloadSlot),
    .spriteRdSlot(spriteRdSlot), .spriteWrSlot(spriteWrSlot)
  );

  int testsRun = 0, testsFailed = 0, totalCyc = 0;
  bit done = 0;
  always @(posedge clk) totalCyc <= totalCyc + 1;

  bit          opWr[64];
  logic [15:0] opAddr[64];
  int nOps, reqCyc, probeCyc;
  int expStall, expSmp, expRld, expSpr;
  int runCycles, nSmp, nRld, nRd, nWr, badPar;
  logic probeRdy, probeOwn, put0, put1, rdy0, own0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    wait (totalCyc >= LIMIT);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog all-requirements actual=%0d expected=%0d", totalCyc, LIMIT);
      summary();
      $finish;
    end
  end

  function automatic int smpLen(input int h);
    return (h % 2 == 0) ? 3 : 4;
  endfunction
  function automatic int sprLen(input int h);
    return (h % 2 == 0) ? 514 : 513;
  endfunction

  task automatic addOp(input bit wr, input logic [15:0] a);
    opWr[nOps] = wr; opAddr[nOps] = a; nOps++;
  endtask

  // builds a CPU script and the expected outcome from the requirements
  task automatic build(input int scn, input int p, input int k, input bit wv);
    int h;
    nOps = 0; reqCyc = -1; probeCyc = -1;
    expSmp = 0; expRld = 0; expSpr = 0;
    for (int i = 0; i < p; i++) addOp(0, RD_A);
    case (scn)
      0: begin // R3 plain fetch, R2 writes postpone
        addOp(0, RD_A); reqCyc = p; probeCyc = p + 1;
        for (int i = 0; i < k; i++) addOp(1, WR_A);
        h = p + 1 + k; expStall = smpLen(h); expSmp = 1;
      end
      1: begin // R7 load + reload, R9/R10 drop
        addOp(1, EN_A);
        for (int i = 0; i < k; i++) addOp(1, WR_A);
        h = p + 1 + k;
        addOp(0, RD_A);
        addOp(wv, wv ? WR_A : RD_A);
        expStall = smpLen(h) + 4 + (wv ? 0 : 1); expSmp = 1; expRld = 1;
      end
      2, 3, 5: begin // R4, R5, R6
        addOp(1, SPR_A);
        for (int i = 0; i < k; i++) addOp(1, WR_A);
        h = p + 1 + k; expStall = sprLen(h); expSpr = 256;
        if (scn == 3) begin reqCyc = p; expStall += 2; expSmp = 1; end
        if (scn == 5) begin reqCyc = p + 21 + k; expStall += 2; expSmp = 1; end
      end
      default: begin // R8, R11
        addOp(1, EN_A); addOp(1, SPR_A);
        for (int i = 0; i < k; i++) addOp(1, WR_A);
        h = p + 2 + k; expStall = sprLen(h) + 4; expSmp = 1; expRld = 1; expSpr = 256;
      end
    endcase
    for (int i = 0; i < 12; i++) addOp(0, RD_A);
  endtask

  task automatic runScript();
    int idx = 0;
    int cyc = 0;
    bit adv;
    nSmp = 0; nRld = 0; nRd = 0; nWr = 0; badPar = 0;
    rstN = 0; cpuWrite = 0; cpuAddr = RD_A; sampleReq = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    while (idx < nOps && cyc < 3000) begin
      cpuWrite = opWr[idx]; cpuAddr = opAddr[idx]; sampleReq = (cyc == reqCyc);
      @(negedge clk);
      if (cyc == 0) begin put0 = putCycle; rdy0 = cpuRdy; own0 = dmaOwn; end
      if (cyc == 1) put1 = putCycle;
      if (cyc == probeCyc) begin probeRdy = cpuRdy; probeOwn = dmaOwn; end
      if (sampleSlot)   begin nSmp++; if (putCycle)  badPar++; end
      if (reloadSlot)   begin nRld++; if (putCycle)  badPar++; end
      if (spriteRdSlot) begin nRd++;  if (putCycle)  badPar++; end
      if (spriteWrSlot) begin nWr++;  if (!putCycle) badPar++; end
      adv = opWr[idx] || cpuRdy;
      @(posedge clk); #1;
      if (adv) idx++;
      cyc++;
    end
    runCycles = cyc;
    cpuWrite = 0; sampleReq = 0; cpuAddr = RD_A;
  endtask

  task automatic judge(input int scn, input int k, input bit wv);
    string st;
    case (scn)
      0: st = "R3";
      1: st = wv ? "R10" : "R9";
      2: st = "R4";
      3: st = "R5";
      5: st = "R6";
      default: st = "R8";
    endcase
    check(runCycles - nOps == expStall, st, runCycles - nOps, expStall);
    check(nSmp == expSmp, st, nSmp, expSmp);
    if (scn == 1) check(nRld == 1, "R7", nRld, 1);
    if (scn == 4) check(nRld == 1, "R11", nRld, 1);
    if (expSpr != 0) check(nRd == 256 && nWr == 256, "R4", nRd + nWr, 512);
    check(badPar == 0, "R1", badPar, 0);
    if (scn == 0) begin
      // R2: a write after the request keeps the bus free but the CPU stalled
      check(probeRdy == 1'b0, "R2", probeRdy, 0);
      check(probeOwn == (k == 0), "R2", probeOwn, (k == 0));
    end
  endtask

  initial begin
    int unsigned seedSet;
    seedSet = $urandom(32'd5150);
    // reset state and parity
    build(0, 2, 0, 0); runScript();
    check(put0 == 1'b0, "R1", put0, 0);
    check(put1 == 1'b1, "R1", put1, 1);
    check(rdy0 == 1'b1 && own0 == 1'b0, "R2", {rdy0, own0}, 2);
    judge(0, 0, 0);
    // directed corners, both parities of the halt cycle
    for (int s = 0; s < 6; s++) begin
      for (int p = 0; p < 2; p++) begin
        build(s, p, (s == 0) ? 1 : 0, 0); runScript(); judge(s, (s == 0) ? 1 : 0, 0);
      end
    end
    build(1, 0, 1, 1); runScript(); judge(1, 1, 1); // R10 write at drop slot
    build(1, 1, 0, 1); runScript(); judge(1, 0, 1); // R10 other parity
    build(1, 1, 2, 0); runScript(); judge(1, 2, 0); // R9 delayed load
    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int s, p, k;
      bit wv;
      s  = int'($urandom_range(0, 5));
      p  = int'($urandom_range(0, 5));
      k  = int'($urandom_range(0, 2));
      wv = 1'($urandom_range(0, 1));
      build(s, p, k, wv); runScript(); judge(s, k, wv);
    end
    done = 1;
    summary();
    $finish;
  end

endmodule